// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This block decides where execution goes when the core takes a fault or trap, and where it resumes when a privileged return executes. The rest of the core reports one event per cycle. That event is a fault with its cause code, or a return strobe, together with the current PC and whether the core already runs privileged code. One clock later the unit answers with a redirect strobe, the new target PC and the PC after it, and an updated exception-restart register. It also raises one-cycle requests to swap the shadow register bank in or out. Fault detection, instruction fetch and the register file itself are outside the block.

Every handler address is the privileged base register plus a fixed, sparse per-cause offset. Every offset has bit 0 set, so a handler address carries a privileged-execution mark. The base register has its own write port. Arithmetic causes are reserved: they do not redirect, and they set a sticky error output.

Top module: `trap_unit`

## Requirements
- R1: While reset is low, `redirect_valid`, `shadow_enter`, `shadow_exit`, `irq_rearm` and `unimpl_err` are 0, `restart_addr` is 0, `target_pc` is BASE_RST+1 and `next_pc` is BASE_RST+5. On the first clock edge after reset is released, `redirect_valid` pulses for one cycle with that target.
- R2: A taken fault redirects to base + offset. The cause codes (`fault_code`) map to offsets as follows:
  - 0 reset: 0x0001
  - 1 machine check: 0x0401
  - 3 interrupt: 0x0101
  - 4 data-translation miss, native: 0x0201
  - 5 data-translation miss, privileged: 0x0281
  - 6 alignment: 0x0301
  - 7 data-translation fault: 0x0381
  - 8 data access violation: 0x0381
  - 9 instruction-translation miss: 0x0181
  - 10 instruction-translation fault: 0x0181
  - 11 instruction access violation: 0x0081
  - 12 unimplemented opcode: 0x0481
  - 13 FP disabled: 0x0581
  - 14 privileged call: 0x2001
- R3: Whenever `redirect_valid` is 1, `next_pc` equals `target_pc` + 4.
- R4: A taken fault other than the privileged call (code 14) or an interrupt in privileged mode loads `restart_addr` with the current PC.
- R5: A privileged call (code 14) loads `restart_addr` with the current PC + 4, so the calling instruction is skipped.
- R6: An interrupt (code 3) taken with `priv_mode`=1 leaves `restart_addr` unchanged. Taken with `priv_mode`=0 it loads the current PC.
- R7: `shadow_enter` pulses exactly when a fault is taken with `priv_mode`=0. It stays 0 for faults taken with `priv_mode`=1.
- R8: A return with `priv_mode`=1 redirects to the current `restart_addr` and pulses `irq_rearm`. It pulses `shadow_exit` only when bit 0 of `restart_addr` is 0.
- R9: A return with `priv_mode`=0 is taken as an unimplemented-opcode fault: target is base+0x0481, `restart_addr` is loaded with the current PC, `shadow_enter` pulses, and there is no `irq_rearm`.
- R10: Arithmetic codes 2 and 15 produce no redirect and leave `restart_addr` unchanged. They set `unimpl_err`, which stays 1 until reset.
- R11: `base_we` loads `base_wdata` into the base register. An event in the same cycle still uses the old base, and events from the next cycle use the new one.
- R12: When a fault and a return arrive in the same cycle, the fault is taken and the return is dropped (no `irq_rearm`, no `shadow_exit`).
- R13: Every output changes on the clock edge that samples the event, and the strobes last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_valid | input | 1 | A fault or trap is reported this cycle |
| fault_code | input | 4 | Cause code of the reported fault |
| cur_pc | input | XLEN | PC of the faulting or returning instruction |
| priv_mode | input | 1 | Core currently runs privileged code |
| ret_valid | input | 1 | A privileged return executes this cycle |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | XLEN | New base register value |
| redirect_valid | output | 1 | Fetch must restart at `target_pc` |
| target_pc | output | XLEN | Redirect target |
| next_pc | output | XLEN | Target + 4 |
| restart_addr | output | XLEN | Exception-restart register |
| shadow_enter | output | 1 | Swap the shadow register bank in |
| shadow_exit | output | 1 | Swap the shadow register bank out |
| irq_rearm | output | 1 | Interrupt checking must resume |
| unimpl_err | output | 1 | Sticky: an arithmetic trap was reported |

## Verification
The bench builds the unit with XLEN=32 and BASE_RST=0x0001_0000. At that base the largest offset (0x2001) cannot carry into the base bits, so every target reads back as base and offset side by side. A later base write to 0x0040_0000 shows that the whole register is used, not just the low bits. With a 32-bit PC, odd restart addresses reached through privileged faults make both outcomes of the bit-0 check on return observable.

// File: rtl/trap_pkg.sv
// Shared cause codes and the fixed vector-offset table of the trap unit.
// Assumes a 4-bit cause code; every offset has bit 0 set as a privileged mark.
package trap_pkg;

    typedef enum logic [3:0] {
        FC_RESET     = 4'd0,
        FC_MCHK      = 4'd1,
        FC_ARITH     = 4'd2,
        FC_IRQ       = 4'd3,
        FC_DMISS_NAT = 4'd4,
        FC_DMISS_PRV = 4'd5,
        FC_ALIGN     = 4'd6,
        FC_DFAULT    = 4'd7,
        FC_DACV      = 4'd8,
        FC_IMISS     = 4'd9,
        FC_IFAULT    = 4'd10,
        FC_IACV      = 4'd11,
        FC_OPCDEC    = 4'd12,
        FC_FPDIS     = 4'd13,
        FC_PCALL     = 4'd14,
        FC_INTOVF    = 4'd15
    } fault_e;

    localparam int OFS_W = 14;

    // Handler offset from the base register for each cause
    function automatic logic [OFS_W-1:0] vec_offset(input fault_e f);
        case (f)
            FC_RESET:                 return 14'h0001;
            FC_MCHK:                  return 14'h0401;
            FC_ARITH, FC_INTOVF:      return 14'h0501;
            FC_IRQ:                   return 14'h0101;
            FC_DMISS_NAT:             return 14'h0201;
            FC_DMISS_PRV:             return 14'h0281;
            FC_ALIGN:                 return 14'h0301;
            FC_DFAULT, FC_DACV:       return 14'h0381;
            FC_IMISS, FC_IFAULT:      return 14'h0181;
            FC_IACV:                  return 14'h0081;
            FC_OPCDEC:                return 14'h0481;
            FC_FPDIS:                 return 14'h0581;
            FC_PCALL:                 return 14'h2001;
            default:                  return 14'h0001;
        endcase
    endfunction

    // Reserved arithmetic classes that must not redirect
    function automatic logic is_arith(input fault_e f);
        return (f == FC_ARITH) || (f == FC_INTOVF);
    endfunction

endpackage

// File: rtl/trap_vec_table.sv
// Forms the handler target and the following PC from base and cause.
// Pure combinational; assumes XLEN is wider than the offset field.
module trap_vec_table
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  fault_e          code,
    output logic [XLEN-1:0] tgt,
    output logic [XLEN-1:0] tgt_next
);
    localparam int PAD_W = XLEN - OFS_W;

    logic [XLEN-1:0] ofs_ext;

    // Zero-extend the table offset and add it to the base
    always_comb begin
        ofs_ext  = {{PAD_W{1'b0}}, vec_offset(code)};
        tgt      = base + ofs_ext;
        tgt_next = base + ofs_ext + XLEN'(4);
    end
endmodule

// File: rtl/trap_restart_sel.sv
// Chooses the next exception-restart value for a taken fault.
// Assumes the caller only uses the result when a fault is actually taken.
module trap_restart_sel
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] restart_q,
    input  fault_e          code,
    input  logic            priv,
    output logic [XLEN-1:0] restart_d
);
    // Trap class skips the instruction, a nested interrupt keeps the old value
    always_comb begin
        if (code == FC_PCALL || is_arith(code))
            restart_d = cur_pc + XLEN'(4);
        else if (code == FC_IRQ && priv)
            restart_d = restart_q;
        else
            restart_d = cur_pc;
    end
endmodule

// File: rtl/trap_unit.sv
// Trap entry and privileged return sequencer.
// Takes one event per cycle (fault beats return), answers one cycle later with
// a registered redirect, restart register update and shadow-bank requests.
// Assumes the surrounding core holds further events off while it redirects.
module trap_unit
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] BASE_RST = 32'h0001_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_valid,
    input  logic [3:0]      fault_code,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            priv_mode,
    input  logic            ret_valid,
    input  logic            base_we,
    input  logic [XLEN-1:0] base_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] target_pc,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] restart_addr,
    output logic            shadow_enter,
    output logic            shadow_exit,
    output logic            irq_rearm,
    output logic            unimpl_err
);
    localparam logic [XLEN-1:0] BOOT_PC  = BASE_RST + XLEN'(vec_offset(FC_RESET));
    localparam logic [XLEN-1:0] BOOT_NXT = BOOT_PC + XLEN'(4);

    logic [XLEN-1:0] base_q;
    logic            boot_q;
    fault_e          in_code;
    fault_e          eff_code;
    logic            bad_ret;
    logic            good_ret;
    logic            arith_hit;
    logic            take_fault;
    logic [XLEN-1:0] vec_tgt;
    logic [XLEN-1:0] vec_nxt;
    logic [XLEN-1:0] restart_d;

    // Classify the incoming event
    always_comb begin
        in_code    = fault_e'(fault_code);
        bad_ret    = ret_valid && !priv_mode && !fault_valid;
        good_ret   = ret_valid &&  priv_mode && !fault_valid;
        arith_hit  = fault_valid && is_arith(in_code);
        take_fault = (fault_valid && !is_arith(in_code)) || bad_ret;
        eff_code   = bad_ret ? FC_OPCDEC : in_code;
    end

    trap_vec_table #(.XLEN(XLEN)) u_vec (
        .base     (base_q),
        .code     (eff_code),
        .tgt      (vec_tgt),
        .tgt_next (vec_nxt)
    );

    trap_restart_sel #(.XLEN(XLEN)) u_rsel (
        .cur_pc    (cur_pc),
        .restart_q (restart_addr),
        .code      (eff_code),
        .priv      (priv_mode),
        .restart_d (restart_d)
    );

    // Base register and boot-redirect flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
            boot_q <= 1'b1;
        end else begin
            boot_q <= 1'b0;
            if (base_we) base_q <= base_wdata;
        end
    end

    // Redirect target and restart register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            target_pc      <= BOOT_PC;
            next_pc        <= BOOT_NXT;
            restart_addr   <= '0;
        end else begin
            redirect_valid <= boot_q || take_fault || good_ret;
            if (take_fault) begin
                target_pc    <= vec_tgt;
                next_pc      <= vec_nxt;
                restart_addr <= restart_d;
            end else if (good_ret) begin
                target_pc <= restart_addr;
                next_pc   <= restart_addr + XLEN'(4);
            end
        end
    end

    // Shadow-bank, re-arm strobes and sticky arithmetic error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_enter <= 1'b0;
            shadow_exit  <= 1'b0;
            irq_rearm    <= 1'b0;
            unimpl_err   <= 1'b0;
        end else begin
            shadow_enter <= take_fault && !priv_mode;
            shadow_exit  <= good_ret && !restart_addr[0];
            irq_rearm    <= good_ret;
            unimpl_err   <= unimpl_err || arith_hit;
        end
    end
endmodule

// File: rtl/trap_unit_chk.sv
// Property checker for trap_unit, attached by bind; observes ports only.
module trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fault_valid,
    input logic [3:0]      fault_code,
    input logic            priv_mode,
    input logic            ret_valid,
    input logic            redirect_valid,
    input logic [XLEN-1:0] target_pc,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] restart_addr,
    input logic            shadow_enter,
    input logic            shadow_exit,
    input logic            irq_rearm,
    input logic            unimpl_err
);
    // R3
    next_follows_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> next_pc == target_pc + XLEN'(4));

    // R7
    enter_needs_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_enter |-> redirect_valid && !irq_rearm);

    // R8
    exit_needs_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_exit |-> irq_rearm && redirect_valid);

    // R8
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && priv_mode && !fault_valid)
        |=> redirect_valid && target_pc == $past(restart_addr));

    // R6
    nested_irq_keeps_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == 4'd3 && priv_mode)
        |=> $stable(restart_addr));

    // R10
    arith_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (fault_code == 4'd2 || fault_code == 4'd15))
        |=> !redirect_valid && unimpl_err && $stable(restart_addr));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_err |=> unimpl_err);

    // R12
    fault_beats_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && ret_valid) |=> !irq_rearm && !shadow_exit);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_valid    (fault_valid),
    .fault_code     (fault_code),
    .priv_mode      (priv_mode),
    .ret_valid      (ret_valid),
    .redirect_valid (redirect_valid),
    .target_pc      (target_pc),
    .next_pc        (next_pc),
    .restart_addr   (restart_addr),
    .shadow_enter   (shadow_enter),
    .shadow_exit    (shadow_exit),
    .irq_rearm      (irq_rearm),
    .unimpl_err     (unimpl_err)
);

// File: tb/trap_unit_tb.sv
module trap_unit_tb;
    localparam int          XLEN = 32;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [3:0]  fault_code = '0;
    logic [31:0] cur_pc = '0;
    logic        priv_mode = 1'b0;
    logic        ret_valid = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        redirect_valid, shadow_enter, shadow_exit, irq_rearm, unimpl_err;
    logic [31:0] target_pc, next_pc, restart_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trap_unit #(.XLEN(XLEN), .BASE_RST(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_code(fault_code),
        .cur_pc(cur_pc), .priv_mode(priv_mode), .ret_valid(ret_valid),
        .base_we(base_we), .base_wdata(base_wdata),
        .redirect_valid(redirect_valid), .target_pc(target_pc), .next_pc(next_pc),
        .restart_addr(restart_addr), .shadow_enter(shadow_enter),
        .shadow_exit(shadow_exit), .irq_rearm(irq_rearm), .unimpl_err(unimpl_err)
    );

    // Offsets as listed in the requirements
    function automatic logic [31:0] exp_ofs(input int c);
        case (c)
            0: return 32'h0001;   1: return 32'h0401;   3: return 32'h0101;
            4: return 32'h0201;   5: return 32'h0281;   6: return 32'h0301;
            7: return 32'h0381;   8: return 32'h0381;   9: return 32'h0181;
            10: return 32'h0181;  11: return 32'h0081;  12: return 32'h0481;
            13: return 32'h0581;  14: return 32'h2001;  default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one event for one cycle; outputs are valid on return
    task automatic fire(input logic fv, input logic [3:0] fc, input logic [31:0] pc,
                        input logic pr, input logic rv);
        fault_valid = fv; fault_code = fc; cur_pc = pc; priv_mode = pr; ret_valid = rv;
        @(negedge clk);
        fault_valid = 1'b0; ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 redirect in reset", 32'(redirect_valid), 0);
        check("R1 target in reset", target_pc, BASE + 1);
        check("R1 next in reset", next_pc, BASE + 5);
        check("R1 restart in reset", restart_addr, 0);
        check("R1 err in reset", 32'(unimpl_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 boot redirect", 32'(redirect_valid), 1);
        check("R1 boot target", target_pc, BASE + 1);
        @(negedge clk);
        check("R13 boot pulse ends", 32'(redirect_valid), 0);
    endtask

    task automatic t_vectors();
        for (int c = 0; c < 15; c++) begin
            if (c == 2) continue;
            fire(1'b1, 4'(c), 32'h0000_4000 + 32'(c) * 16, 1'b0, 1'b0);
            check($sformatf("R2 target code %0d", c), target_pc, BASE + exp_ofs(c));
            check("R3 next_pc", next_pc, BASE + exp_ofs(c) + 4);
            check("R7 shadow_enter user", 32'(shadow_enter), 1);
            check("R13 redirect", 32'(redirect_valid), 1);
            if (c == 14) check("R5 pcall restart", restart_addr, 32'h0000_4000 + 32'(c) * 16 + 4);
            else check("R4 restart", restart_addr, 32'h0000_4000 + 32'(c) * 16);
            @(negedge clk);
            check("R13 pulse ends", 32'(redirect_valid | shadow_enter), 0);
        end
    endtask

    task automatic t_priv_faults();
        fire(1'b1, 4'd1, 32'h0000_7001, 1'b1, 1'b0);
        check("R7 no shadow_enter priv", 32'(shadow_enter), 0);
        check("R4 restart priv odd", restart_addr, 32'h0000_7001);
        fire(1'b1, 4'd3, 32'h0000_9990, 1'b1, 1'b0);
        check("R6 nested irq keeps restart", restart_addr, 32'h0000_7001);
        check("R6 nested irq target", target_pc, BASE + 32'h0101);
        fire(1'b1, 4'd3, 32'h0000_5550, 1'b0, 1'b0);
        check("R6 user irq restart", restart_addr, 32'h0000_5550);
    endtask

    task automatic t_returns();
        fire(1'b1, 4'd6, 32'h0000_3000, 1'b1, 1'b0);
        fire(1'b0, 4'd0, 32'h0000_1234, 1'b1, 1'b1);
        check("R8 return target", target_pc, 32'h0000_3000);
        check("R8 return next", next_pc, 32'h0000_3004);
        check("R8 rearm", 32'(irq_rearm), 1);
        check("R8 shadow_exit even", 32'(shadow_exit), 1);
        fire(1'b1, 4'd6, 32'h0000_3001, 1'b1, 1'b0);
        fire(1'b0, 4'd0, 32'h0000_1234, 1'b1, 1'b1);
        check("R8 return odd target", target_pc, 32'h0000_3001);
        check("R8 no shadow_exit odd", 32'(shadow_exit), 0);
        fire(1'b0, 4'd0, 32'h0000_6660, 1'b0, 1'b1);
        check("R9 bad return target", target_pc, BASE + 32'h0481);
        check("R9 bad return restart", restart_addr, 32'h0000_6660);
        check("R9 bad return enter", 32'(shadow_enter), 1);
        check("R9 bad return no rearm", 32'(irq_rearm), 0);
    endtask

    task automatic t_priority();
        fire(1'b1, 4'd13, 32'h0000_8000, 1'b1, 1'b1);
        check("R12 fault wins target", target_pc, BASE + 32'h0581);
        check("R12 no rearm", 32'(irq_rearm | shadow_exit), 0);
    endtask

    task automatic t_base();
        base_we = 1'b1; base_wdata = 32'h0040_0000;
        fire(1'b1, 4'd9, 32'h0000_2220, 1'b0, 1'b0);
        base_we = 1'b0;
        check("R11 same-cycle old base", target_pc, BASE + 32'h0181);
        fire(1'b1, 4'd9, 32'h0000_2220, 1'b0, 1'b0);
        check("R11 new base", target_pc, 32'h0040_0181);
    endtask

    task automatic t_arith();
        logic [31:0] r;
        r = restart_addr;
        check("R10 err clear before", 32'(unimpl_err), 0);
        fire(1'b1, 4'd2, 32'h0000_aaa0, 1'b0, 1'b0);
        check("R10 arith no redirect", 32'(redirect_valid), 0);
        check("R10 arith restart kept", restart_addr, r);
        check("R10 err set", 32'(unimpl_err), 1);
        fire(1'b1, 4'd15, 32'h0000_bbb0, 1'b0, 1'b0);
        check("R10 intovf no redirect", 32'(redirect_valid | shadow_enter), 0);
        repeat (3) @(negedge clk);
        check("R10 err sticky", 32'(unimpl_err), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 err cleared by reset", 32'(unimpl_err), 0);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_vectors();
        t_priv_faults();
        t_returns();
        t_priority();
        t_arith();
        t_base();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule